// File: doc/BRIEF.md
# Single-to-Half Float Pair Packer

This block takes two IEEE-754 single-precision values and turns each into a half-precision value. It places both halves in one 32-bit word. Each of the two lanes keeps its sign bit as it is. The lane then picks one of four paths for the magnitude, chosen by the biased single-precision exponent and by whether the mantissa is zero: NaN, saturate to infinity, normal half, or subnormal half. All rounding is to nearest, with ties going to the even value.

A producer presents both operands with a valid strobe. With the default setting, the packed word and its valid flag come out of a register one clock later. The register keeps the last word until the next valid input. The parameter `REG_OUT` can remove that register, which makes the whole path combinational.

Top module: `half_pair_packer`

## Requirements
- R1: Lane A's half result occupies outWord[15:0] and lane B's half result occupies outWord[31:16].
- R2: The sign of each half result (bit 15 of the lane field) equals bit 31 of its single-precision input, on every path including NaN, zero and infinity.
- R3: An input with exponent field bits 30:23 equal to 255 and a nonzero mantissa (bits 22:0) yields the lane magnitude 0x7FFF.
- R4: An input with biased exponent 143 or above (this includes infinity, exponent 255 with a zero mantissa) yields the magnitude 0x7C00.
- R5: For biased exponents 113 to 142, the half exponent (bits 14:10) is the input exponent minus 112. The half mantissa (bits 9:0) is input bits 22:13. It is rounded up when bit 12 is set and either any of bits 11:0 or bit 13 is set.
- R6: When the mantissa rounding of R5 overflows, the carry moves into the exponent. A value at exponent 142 can round up to 0x7C00 in this way.
- R7: For biased exponents below 113, the magnitude is |x|·2^24 rounded half-to-even to an integer. This gives zero, a subnormal, or exactly 0x0400 when the value rounds up to the smallest normal.
- R8: With REG_OUT=1, outValid is high in the cycle after inValid was sampled high and low otherwise. outWord updates only on a sampled inValid and holds its value otherwise.
- R9: While rstN is low and just after it, outValid is 0 and outWord is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands on inA and inB are valid this cycle |
| inA | input | 32 | First single-precision operand (low half of result) |
| inB | input | 32 | Second single-precision operand (high half of result) |
| outValid | output | 1 | outWord holds a fresh result |
| outWord | output | 32 | Packed pair of half-precision results |

## Verification
Each converted word, and its valid flag, is due on the first rising edge after the operands are presented, because only the output register lies between input and output. The bench drives operands on a falling edge. It reads outValid and outWord on the next falling edge, half a period after that register has loaded. The hold check keeps inValid low for several edges while the operands change. It then reads the port again to confirm that the word has not moved.

// File: rtl/hpk_pkg.sv
package hpk_pkg;
  // single-precision field geometry
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_MAN_W  = 23;
  localparam int SGL_W      = 1 + SGL_EXP_W + SGL_MAN_W;
  localparam int SGL_BIAS   = (1 << (SGL_EXP_W - 1)) - 1;
  // half-precision field geometry
  localparam int HLF_EXP_W  = 5;
  localparam int HLF_MAN_W  = 10;
  localparam int HLF_W      = 1 + HLF_EXP_W + HLF_MAN_W;
  localparam int HLF_BIAS   = (1 << (HLF_EXP_W - 1)) - 1;
  localparam int MAG_W      = HLF_W - 1;
  // derived thresholds on the biased single exponent
  localparam int EXP_OFF    = SGL_BIAS - HLF_BIAS;       // 112
  localparam int SUBN_LIM   = EXP_OFF + 1;               // 113
  localparam int OVF_LIM    = SGL_BIAS + HLF_BIAS + 1;   // 143
  localparam int DROP_W     = SGL_MAN_W - HLF_MAN_W;     // 13
  localparam int SIG_W      = SGL_MAN_W + 1;
  localparam int SUB_SCALE  = HLF_BIAS - 1 + HLF_MAN_W;  // 24
  localparam int SUB_SHBASE = SGL_BIAS + SGL_MAN_W - SUB_SCALE; // 126
  localparam int LANES      = 2;
  localparam int WORD_W     = LANES * HLF_W;

  typedef struct packed {
    logic loadEn;
    logic validQ;
  } hpkStrobe_t;
endpackage

// File: rtl/hpk_lane.sv
module hpk_lane
  import hpk_pkg::*;
(
  input  logic [SGL_W-1:0] fIn,
  output logic [HLF_W-1:0] hOut
);
  localparam int EXT_W = SIG_W + SUB_SCALE;
  localparam int KEEP_W = HLF_MAN_W + SUB_SCALE;

  logic                 sgn;
  logic [SGL_EXP_W-1:0] expS;
  logic [SGL_MAN_W-1:0] manS;
  logic                 isNan, isBig, isSmall;

  assign sgn  = fIn[SGL_W-1];
  assign expS = fIn[SGL_W-2 -: SGL_EXP_W];
  assign manS = fIn[SGL_MAN_W-1:0];

  assign isNan   = (expS == '1) && (manS != '0);
  assign isBig   = expS >= SGL_EXP_W'(OVF_LIM);
  assign isSmall = expS <  SGL_EXP_W'(SUBN_LIM);

  // normal path: rebias exponent, trim mantissa with round-half-even
  logic [HLF_EXP_W-1:0] expH;
  logic                 guardN, stickyN, lsbN, rndN;
  logic [MAG_W-1:0]     normMag;

  assign expH    = HLF_EXP_W'(expS - SGL_EXP_W'(EXP_OFF));
  assign guardN  = manS[DROP_W-1];
  assign stickyN = |manS[DROP_W-2:0];
  assign lsbN    = manS[DROP_W];
  assign rndN    = guardN & (stickyN | lsbN);
  assign normMag = {expH, manS[SGL_MAN_W-1:DROP_W]} + MAG_W'(rndN);

  // small path: scale magnitude by 2^24 through a right shift, round half-even
  logic [SIG_W-1:0]     sig;
  logic [SGL_EXP_W-1:0] shAmt;
  logic [KEEP_W-1:0]    ext;
  logic                 guardS, stickyS, lsbS, rndS;
  logic [MAG_W-1:0]     smallMag;

  assign sig      = {expS != '0, manS};
  assign shAmt    = SGL_EXP_W'(SUB_SHBASE) - expS;
  assign ext      = KEEP_W'({sig, {SUB_SCALE{1'b0}}} >> shAmt);
  assign guardS   = ext[SUB_SCALE-1];
  assign stickyS  = |ext[SUB_SCALE-2:0];
  assign lsbS     = ext[SUB_SCALE];
  assign rndS     = guardS & (stickyS | lsbS);
  assign smallMag = MAG_W'(ext[KEEP_W-1:SUB_SCALE]) + MAG_W'(rndS);

  logic [MAG_W-1:0] mag;
  always_comb begin
    if (isNan)        mag = '1;
    else if (isBig)   mag = {{HLF_EXP_W{1'b1}}, {HLF_MAN_W{1'b0}}};
    else if (isSmall) mag = smallMag;
    else              mag = normMag;
  end

  assign hOut = {sgn, mag};

  // the shifted window never carries bits above the kept field for small inputs
  always_comb begin
    if (isSmall && !isNan) begin
      // R7
      small_range_chk: assert (mag <= MAG_W'(1 << HLF_MAN_W));
    end
  end
endmodule

// File: rtl/hpk_datapath.sv
module hpk_datapath
  import hpk_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  hpkStrobe_t        strobe,
  input  logic [SGL_W-1:0]  inA,
  input  logic [SGL_W-1:0]  inB,
  output logic [WORD_W-1:0] outWord
);
  logic [LANES-1:0][SGL_W-1:0] laneIn;
  logic [LANES-1:0][HLF_W-1:0] laneOut;
  logic [WORD_W-1:0]           packedWord;

  assign laneIn = {inB, inA};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    hpk_lane u_lane (
      .fIn (laneIn[g]),
      .hOut(laneOut[g])
    );
    assign packedWord[g*HLF_W +: HLF_W] = laneOut[g];
  end

  if (REG_OUT) begin : g_reg
    logic [WORD_W-1:0] wordQ;
    always_ff @(posedge clk) begin
      if (!rstN)              wordQ <= '0;
      else if (strobe.loadEn) wordQ <= packedWord;
    end
    assign outWord = wordQ;

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.loadEn |=> $stable(outWord));
    // R2
    sign_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.loadEn |=> (outWord[HLF_W-1] == $past(inA[SGL_W-1])) &&
                        (outWord[WORD_W-1] == $past(inB[SGL_W-1])));
    // R3
    nan_pattern_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.loadEn && (inA[SGL_W-2 -: SGL_EXP_W] == '1) && (inA[SGL_MAN_W-1:0] != '0)
      |=> outWord[MAG_W-1:0] == '1);
    // R4
    inf_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.loadEn && (inB[SGL_W-2 -: SGL_EXP_W] >= SGL_EXP_W'(OVF_LIM)) &&
      !((inB[SGL_W-2 -: SGL_EXP_W] == '1) && (inB[SGL_MAN_W-1:0] != '0))
      |=> outWord[HLF_W +: MAG_W] == MAG_W'(15'h7C00));
  end else begin : g_comb
    assign outWord = packedWord;
  end
endmodule

// File: rtl/hpk_ctrl.sv
module hpk_ctrl
  import hpk_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output hpkStrobe_t strobe
);
  logic validQ;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) validQ <= 1'b0;
      else       validQ <= inValid;
    end

    // R8
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> strobe.validQ);
    // R8
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> !strobe.validQ);
  end else begin : g_comb
    assign validQ = inValid;
  end

  assign strobe.loadEn = inValid;
  assign strobe.validQ = validQ;
endmodule

// File: rtl/half_pair_packer.sv
module half_pair_packer
  import hpk_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [SGL_W-1:0]  inA,
  input  logic [SGL_W-1:0]  inB,
  output logic              outValid,
  output logic [WORD_W-1:0] outWord
);
  hpkStrobe_t strobe;

  hpk_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .strobe (strobe)
  );

  hpk_datapath #(.REG_OUT(REG_OUT)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inA    (inA),
    .inB    (inB),
    .outWord(outWord)
  );

  assign outValid = strobe.validQ;
endmodule

// File: tb/half_pair_packer_bench.sv
module half_pair_packer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inA = '0;
  logic [31:0] inB = '0;
  logic        outValid;
  logic [31:0] outWord;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  half_pair_packer u_half_pair_packer (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inA(inA), .inB(inB), .outValid(outValid), .outWord(outWord)
  );

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // drive one pair at a falling edge, read the registered result one edge later
  task automatic runPair(input string req, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] exp);
    @(negedge clk);
    inA = a; inB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check32({req, " valid"}, {31'b0, outValid}, 32'd1);
    check32(req, outWord, exp);
  endtask

  task automatic testReset();
    @(negedge clk);
    check32("R9 valid", {31'b0, outValid}, 32'd0);
    check32("R9 word", outWord, 32'h0);
  endtask

  task automatic testPacking();
    runPair("R1 1.0|-2.0", 32'h3F800000, 32'hC0000000, 32'hC0003C00);
    runPair("R1 0.5|1.0",  32'h3F000000, 32'h3F800000, 32'h3C003800);
    runPair("R2 signed zeros", 32'h80000000, 32'h00000000, 32'h00008000);
  endtask

  task automatic testNan();
    runPair("R3 nan quiet|neg nan", 32'h7FC00000, 32'hFF800001, 32'hFFFF7FFF);
  endtask

  task automatic testOverflow();
    runPair("R4 inf|-inf",          32'h7F800000, 32'hFF800000, 32'hFC007C00);
    runPair("R4 65536|65504",       32'h47800000, 32'h477FE000, 32'h7BFF7C00);
  endtask

  task automatic testNormalRound();
    runPair("R5 tie even|tie odd",  32'h3F801000, 32'h3F803000, 32'h3C023C00);
    runPair("R5 above|below half",  32'h3F801001, 32'h3F800FFF, 32'h3C003C01);
    runPair("R5 min normal",        32'h38800000, 32'h00000000, 32'h00000400);
  endtask

  task automatic testCarry();
    runPair("R6 carry to 2.0|to inf", 32'h3FFFF000, 32'h477FF000, 32'h7C004000);
  endtask

  task automatic testSubnormal();
    runPair("R7 2^-24|2^-25 tie",   32'h33800000, 32'h33000000, 32'h00000001);
    runPair("R7 above tie|1.5 tie", 32'h33000001, 32'h33C00000, 32'h00020001);
    runPair("R7 2^-15|to min norm", 32'h38000000, 32'h387FFFFF, 32'h04000200);
    runPair("R7 f32 denorm|-tiny",  32'h00000001, 32'h80000001, 32'h80000000);
  endtask

  task automatic testHold();
    logic [31:0] last;
    runPair("R8 load", 32'h3F800000, 32'h3F000000, 32'h38003C00);
    last = outWord;
    @(negedge clk);
    inA = 32'h7F800000; inB = 32'hFFC00000;
    repeat (3) @(negedge clk);
    check32("R8 idle valid", {31'b0, outValid}, 32'd0);
    check32("R8 hold word", outWord, last);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPacking();
    testNan();
    testOverflow();
    testNormalRound();
    testCarry();
    testSubnormal();
    testHold();
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end
endmodule